// File: doc/BRIEF.md
# Codec Register Access Port

This block is the command and status half of an AC'97-style link controller. Software reaches the registers of an external audio codec through the two command slots of each link frame. The address slot carries the register index, and the data slot carries the 16-bit value. A small word-addressed register bus gives access to the transmit and receive words of both slots, a flag word, a control word and a codec reset word.

The link side is abstracted to one exchange per frame. On each `frame_tick` the block can present the pending slot words for one cycle, and it samples any slot words the codec returned. A write is started by loading the data slot and then the address slot. Loading the address slot arms the pair, and it leaves in the next frame. A read is the address slot with its request bit set. The codec's answer is accepted when the index it echoes matches the index that was last requested.

The block also drives the active-low codec reset pin. It keeps that pin low for a programmable minimum number of cycles, even if software lets go sooner.

Top module: `car_access_port`

## Requirements
- R1: Register word offsets are: 0 slot-1 transmit, 1 slot-2 transmit, 2 slot-1 receive, 3 slot-2 receive, 4 flags, 5 control, 6 codec reset. After reset the flags read 0x280, the control reads 0, the codec reset word reads 0 and `codec_rst_n` is low.
- R2: A slot word puts the register index at bits 18:12 and the register data at bits 19:4. When slot 2 has been loaded, then slot 1, the next `frame_tick` shows both words on `tx_slot1`/`tx_slot2` with their valid bits high for the following cycle.
- R3: A loaded slot-2 word is never sent on its own. It waits at frame ticks until a slot-1 word goes out with it.
- R4: Flag bit 1 (slot-1 busy) and bit 3 (slot-2 busy) are set from the load until the slot is sent. Bits 7 and 9 read as the inverse of bits 1 and 3 (transmit register empty).
- R5: A slot is sent only while its transmit enable in control is set: bit 4 for slot 1 and bit 6 for slot 2. Otherwise it stays busy.
- R6: At a `frame_tick` with the received valid input high and the receive enable set (control bit 3 for slot 1, bit 5 for slot 2), the received word is stored. Its valid flag is then set: bit 6 for slot 1, bit 8 for slot 2.
- R7: A bus read of a receive register clears its valid flag. A new received word overwrites an unread one.
- R8: Bit 19 of the slot-1 word marks a read request. Flag bit 15 is set when the next captured slot-1 index equals the index of the last sent read request, and cleared when it differs.
- R9: While control bit 0 (interface enable) is low, all busy, valid and echo flags read clear, nothing is sent or captured, and loads do not arm a transfer.
- R10: Control bits 11:10 select the codec and drive `codec_sel`. The control word reads back as written.
- R11: Codec reset word bit 0 low drives `codec_rst_n` low. The pin rises only after it has been low for at least `RST_HOLD_CYCLES` cycles, and only while bit 0 is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (clears receive valid) |
| bus_addr | input | ADDR_W | Register word offset |
| bus_wdata | input | SLOT_W | Write data |
| bus_rdata | output | SLOT_W | Read data for `bus_addr`, combinational |
| frame_tick | input | 1 | One pulse per link frame |
| tx_slot1_valid | output | 1 | Slot-1 word sent this frame |
| tx_slot1 | output | SLOT_W | Outgoing address slot |
| tx_slot2_valid | output | 1 | Slot-2 word sent this frame |
| tx_slot2 | output | SLOT_W | Outgoing data slot |
| rx_slot1_valid | input | 1 | Codec returned slot 1 this frame |
| rx_slot1 | input | SLOT_W | Received address echo |
| rx_slot2_valid | input | 1 | Codec returned slot 2 this frame |
| rx_slot2 | input | SLOT_W | Received register data |
| codec_sel | output | SEL_W | Selected codec number |
| codec_rst_n | output | 1 | Active-low codec reset |

## Verification
The write path is tried three ways: with data loaded before the address, with the data slot loaded alone, and with each transmit enable cleared in turn. These cases separate correct pairing from slot 2 leaking out alone or slots ignoring their enables. Read responses are driven once with a matching echoed index and once with a different one, which separates a real echo comparison from a flag that merely follows capture. Back-to-back captures with no read in between, followed by a capture with the receive enable off, show the difference between overwrite and ignore. The reset pin is released early and then re-requested, which shows whether the minimum low time is measured from the pin itself.

// File: rtl/car_pkg.sv
// Shared constants for the codec register access port: register offsets,
// control and flag bit positions, slot word field positions.
package car_pkg;
    localparam int OFS_S1TX = 0;
    localparam int OFS_S2TX = 1;
    localparam int OFS_S1RX = 2;
    localparam int OFS_S2RX = 3;
    localparam int OFS_FLAG = 4;
    localparam int OFS_CTRL = 5;
    localparam int OFS_RST  = 6;

    localparam int C_IE    = 0;
    localparam int C_S1RX  = 3;
    localparam int C_S1TX  = 4;
    localparam int C_S2RX  = 5;
    localparam int C_S2TX  = 6;
    localparam int C_SEL   = 10;

    localparam int F_BUSY1 = 1;
    localparam int F_BUSY2 = 3;
    localparam int F_VAL1  = 6;
    localparam int F_EMP1  = 7;
    localparam int F_VAL2  = 8;
    localparam int F_EMP2  = 9;
    localparam int F_ECHO  = 15;
    localparam int FLAG_W  = 16;

    localparam int IDX_LSB   = 12;
    localparam int IDX_W     = 7;
    localparam int RDREQ_BIT = 19;
endpackage

// File: rtl/car_tx_slots.sv
// Transmit side: holds the slot-1 and slot-2 words, tracks busy, and sends
// them at a frame tick. Assumes slot 2 only travels together with slot 1.
module car_tx_slots #(
    parameter int SLOT_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ie,
    input  logic              en1,
    input  logic              en2,
    input  logic              tick,
    input  logic              ld1,
    input  logic              ld2,
    input  logic [SLOT_W-1:0] ld_word,
    output logic [SLOT_W-1:0] word1,
    output logic [SLOT_W-1:0] word2,
    output logic              busy1,
    output logic              busy2,
    output logic              send1,
    output logic              tx_v1,
    output logic [SLOT_W-1:0] tx_w1,
    output logic              tx_v2,
    output logic [SLOT_W-1:0] tx_w2
);
    logic send2;

    // Launch decision: slot 1 gates the pair, a same-cycle load takes priority
    always_comb begin
        send1 = tick && ie && en1 && busy1 && !ld1;
        send2 = send1 && en2 && busy2 && !ld2;
    end

    // Stored transmit words
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word1 <= '0;
            word2 <= '0;
        end else begin
            if (ld1) word1 <= ld_word;
            if (ld2) word2 <= ld_word;
        end
    end

    // Busy flags: set on load, clear on send, held clear while disabled
    always_ff @(posedge clk) begin
        if (!rst_n || !ie) begin
            busy1 <= 1'b0;
            busy2 <= 1'b0;
        end else begin
            if (ld1)        busy1 <= 1'b1;
            else if (send1) busy1 <= 1'b0;
            if (ld2)        busy2 <= 1'b1;
            else if (send2) busy2 <= 1'b0;
        end
    end

    // Per-frame outgoing slot words, valid for one cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_v1 <= 1'b0;
            tx_v2 <= 1'b0;
            tx_w1 <= '0;
            tx_w2 <= '0;
        end else begin
            tx_v1 <= send1;
            tx_v2 <= send2;
            tx_w1 <= send1 ? word1 : '0;
            tx_w2 <= send2 ? word2 : '0;
        end
    end

    a_r3_slot2_rides_with_slot1: assert property (@(posedge clk) disable iff (!rst_n)
        tx_v2 |-> tx_v1);
    a_r4_busy1_drop_means_sent: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy1) && $past(ie)) |-> tx_v1);
    a_r4_busy2_drop_means_sent: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy2) && $past(ie)) |-> tx_v2);
    a_r2_send_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        tx_v1 |-> $past(tick));
endmodule

// File: rtl/car_rx_slot.sv
// One receive slot: captures the codec's word at a frame tick and keeps a
// valid flag that a bus read clears. Assumes one word per frame.
module car_rx_slot #(
    parameter int SLOT_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ie,
    input  logic              en,
    input  logic              tick,
    input  logic              in_valid,
    input  logic [SLOT_W-1:0] in_word,
    input  logic              rd_clr,
    output logic              cap,
    output logic [SLOT_W-1:0] word,
    output logic              valid
);
    // Capture strobe for this frame
    always_comb cap = tick && ie && en && in_valid;

    // Held word, overwritten by each capture
    always_ff @(posedge clk) begin
        if (!rst_n)   word <= '0;
        else if (cap) word <= in_word;
    end

    // Valid flag: capture wins over a same-cycle read
    always_ff @(posedge clk) begin
        if (!rst_n || !ie) valid <= 1'b0;
        else if (cap)      valid <= 1'b1;
        else if (rd_clr)   valid <= 1'b0;
    end

    a_r6_valid_from_capture: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(valid) |-> $past(tick && in_valid && en));
    a_r7_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(valid) |-> $past(rd_clr || !ie));
endmodule

// File: rtl/car_rst_timer.sv
// Codec reset pin driver: the pin follows the request but may rise only once
// it has been low for HOLD cycles. Assumes HOLD >= 1.
module car_rst_timer #(
    parameter int HOLD = 500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    output logic pin_n
);
    localparam int CNT_W = $clog2(HOLD + 1);
    logic [CNT_W-1:0] low_cnt;

    // Counts cycles with the pin low, saturating at HOLD
    always_ff @(posedge clk) begin
        if (!rst_n || pin_n)                low_cnt <= '0;
        else if (low_cnt != CNT_W'(HOLD))   low_cnt <= low_cnt + 1'b1;
    end

    // Pin state: drop at once, release only after the hold time
    always_ff @(posedge clk) begin
        if (!rst_n || !req)                 pin_n <= 1'b0;
        else if (low_cnt == CNT_W'(HOLD))   pin_n <= 1'b1;
    end

    a_r11_release_needs_request: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pin_n) |-> $past(req));
endmodule

// File: rtl/car_access_port.sv
// Top of the codec register access port: register bus decode, control and
// reset words, read-echo check and flag word. Assumes single-cycle bus strobes.
module car_access_port #(
    parameter int ADDR_W          = 3,
    parameter int SLOT_W          = 20,
    parameter int NUM_CODECS      = 4,
    parameter int RST_HOLD_CYCLES = 500,
    localparam int SEL_W          = $clog2(NUM_CODECS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [SLOT_W-1:0] bus_wdata,
    output logic [SLOT_W-1:0] bus_rdata,
    input  logic              frame_tick,
    output logic              tx_slot1_valid,
    output logic [SLOT_W-1:0] tx_slot1,
    output logic              tx_slot2_valid,
    output logic [SLOT_W-1:0] tx_slot2,
    input  logic              rx_slot1_valid,
    input  logic [SLOT_W-1:0] rx_slot1,
    input  logic              rx_slot2_valid,
    input  logic [SLOT_W-1:0] rx_slot2,
    output logic [SEL_W-1:0]  codec_sel,
    output logic              codec_rst_n
);
    import car_pkg::*;

    localparam int CTRL_W = C_SEL + SEL_W;
    localparam int NRX    = 2;

    logic [CTRL_W-1:0] ctrl_q;
    logic              rst_req_q;
    logic              ie;
    logic              ld1, ld2;
    logic [SLOT_W-1:0] txw1, txw2;
    logic              busy1, busy2, send1;
    logic [NRX-1:0]    rx_en, rx_in_v, rx_clr, rx_cap, rx_val;
    logic [NRX-1:0][SLOT_W-1:0] rx_in_w, rx_word;
    logic              rd_pend_q;
    logic [IDX_W-1:0]  rd_idx_q;
    logic              echo_q;
    logic [FLAG_W-1:0] flags;

    // Bus write strobes and control fields
    always_comb begin
        ie         = ctrl_q[C_IE];
        ld1        = bus_wr && (bus_addr == ADDR_W'(OFS_S1TX));
        ld2        = bus_wr && (bus_addr == ADDR_W'(OFS_S2TX));
        rx_en[0]   = ctrl_q[C_S1RX];
        rx_en[1]   = ctrl_q[C_S2RX];
        rx_in_v[0] = rx_slot1_valid;
        rx_in_v[1] = rx_slot2_valid;
        rx_in_w[0] = rx_slot1;
        rx_in_w[1] = rx_slot2;
        codec_sel  = ctrl_q[C_SEL +: SEL_W];
    end

    // Control and reset request words
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q    <= '0;
            rst_req_q <= 1'b0;
        end else if (bus_wr) begin
            if (bus_addr == ADDR_W'(OFS_CTRL)) ctrl_q    <= bus_wdata[CTRL_W-1:0];
            if (bus_addr == ADDR_W'(OFS_RST))  rst_req_q <= bus_wdata[0];
        end
    end

    car_tx_slots #(.SLOT_W(SLOT_W)) u_tx (
        .clk(clk), .rst_n(rst_n), .ie(ie),
        .en1(ctrl_q[C_S1TX]), .en2(ctrl_q[C_S2TX]), .tick(frame_tick),
        .ld1(ld1), .ld2(ld2), .ld_word(bus_wdata),
        .word1(txw1), .word2(txw2), .busy1(busy1), .busy2(busy2), .send1(send1),
        .tx_v1(tx_slot1_valid), .tx_w1(tx_slot1),
        .tx_v2(tx_slot2_valid), .tx_w2(tx_slot2)
    );

    for (genvar g = 0; g < NRX; g++) begin : g_rx
        assign rx_clr[g] = bus_rd && (bus_addr == ADDR_W'(OFS_S1RX + g));
        car_rx_slot #(.SLOT_W(SLOT_W)) u_rx (
            .clk(clk), .rst_n(rst_n), .ie(ie), .en(rx_en[g]), .tick(frame_tick),
            .in_valid(rx_in_v[g]), .in_word(rx_in_w[g]), .rd_clr(rx_clr[g]),
            .cap(rx_cap[g]), .word(rx_word[g]), .valid(rx_val[g])
        );
    end

    car_rst_timer #(.HOLD(RST_HOLD_CYCLES)) u_rst (
        .clk(clk), .rst_n(rst_n), .req(rst_req_q), .pin_n(codec_rst_n)
    );

    // Remembers the index of the last read request that went out
    always_ff @(posedge clk) begin
        if (!rst_n || !ie) begin
            rd_pend_q <= 1'b0;
            rd_idx_q  <= '0;
        end else if (send1 && txw1[RDREQ_BIT]) begin
            rd_pend_q <= 1'b1;
            rd_idx_q  <= txw1[IDX_LSB +: IDX_W];
        end
    end

    // Echo flag: updated by each slot-1 capture
    always_ff @(posedge clk) begin
        if (!rst_n || !ie) echo_q <= 1'b0;
        else if (rx_cap[0]) echo_q <= rd_pend_q && (rx_slot1[IDX_LSB +: IDX_W] == rd_idx_q);
    end

    // Flag word assembly
    always_comb begin
        flags          = '0;
        flags[F_BUSY1] = busy1;
        flags[F_BUSY2] = busy2;
        flags[F_EMP1]  = !busy1;
        flags[F_EMP2]  = !busy2;
        flags[F_VAL1]  = rx_val[0];
        flags[F_VAL2]  = rx_val[1];
        flags[F_ECHO]  = echo_q;
    end

    // Read data multiplexer
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            ADDR_W'(OFS_S1TX): bus_rdata = txw1;
            ADDR_W'(OFS_S2TX): bus_rdata = txw2;
            ADDR_W'(OFS_S1RX): bus_rdata = rx_word[0];
            ADDR_W'(OFS_S2RX): bus_rdata = rx_word[1];
            ADDR_W'(OFS_FLAG): bus_rdata = SLOT_W'(flags);
            ADDR_W'(OFS_CTRL): bus_rdata = SLOT_W'(ctrl_q);
            ADDR_W'(OFS_RST):  bus_rdata = SLOT_W'(rst_req_q);
            default:           bus_rdata = '0;
        endcase
    end

    // Checker counter: cycles the codec reset pin has been low
    localparam int LC_W = $clog2(RST_HOLD_CYCLES + 1);
    logic [LC_W-1:0] pin_low_cnt;
    always_ff @(posedge clk) begin
        if (!rst_n || codec_rst_n)                       pin_low_cnt <= '0;
        else if (pin_low_cnt != LC_W'(RST_HOLD_CYCLES))  pin_low_cnt <= pin_low_cnt + 1'b1;
    end

    a_r11_min_low_time: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(codec_rst_n) |-> (pin_low_cnt == LC_W'(RST_HOLD_CYCLES)));
    a_r9_disabled_is_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !ie |=> (!tx_slot1_valid && !tx_slot2_valid && !busy1 && !busy2 && rx_val == '0 && !echo_q));
    a_r8_echo_from_capture: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(echo_q) |-> $past(rx_cap[0]));
endmodule

// File: tb/tb_car_access_port.sv
module tb_car_access_port;
    localparam int HOLD = 500;
    localparam int SW   = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_wr = 1'b0, bus_rd = 1'b0;
    logic [2:0] bus_addr = '0;
    logic [SW-1:0] bus_wdata = '0;
    logic [SW-1:0] bus_rdata;
    logic frame_tick = 1'b0;
    logic tx_slot1_valid, tx_slot2_valid;
    logic [SW-1:0] tx_slot1, tx_slot2;
    logic rx_slot1_valid = 1'b0, rx_slot2_valid = 1'b0;
    logic [SW-1:0] rx_slot1 = '0, rx_slot2 = '0;
    logic [1:0] codec_sel;
    logic codec_rst_n;

    int n_run = 0, n_fail = 0;
    logic g_v1, g_v2;
    logic [SW-1:0] g_w1, g_w2;

    always #2 clk = ~clk;

    car_access_port #(.RST_HOLD_CYCLES(HOLD)) dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .frame_tick(frame_tick),
        .tx_slot1_valid(tx_slot1_valid), .tx_slot1(tx_slot1),
        .tx_slot2_valid(tx_slot2_valid), .tx_slot2(tx_slot2),
        .rx_slot1_valid(rx_slot1_valid), .rx_slot1(rx_slot1),
        .rx_slot2_valid(rx_slot2_valid), .rx_slot2(rx_slot2),
        .codec_sel(codec_sel), .codec_rst_n(codec_rst_n)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr(input int a, input logic [SW-1:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 3'(a); bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input int a, output logic [SW-1:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = 3'(a);
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic peek(input int a, output logic [SW-1:0] d);
        @(negedge clk);
        bus_addr = 3'(a);
        #1 d = bus_rdata;
    endtask

    task automatic tick(input logic v1, input logic [SW-1:0] w1,
                        input logic v2, input logic [SW-1:0] w2);
        @(negedge clk);
        frame_tick = 1'b1;
        rx_slot1_valid = v1; rx_slot1 = w1;
        rx_slot2_valid = v2; rx_slot2 = w2;
        @(negedge clk);
        frame_tick = 1'b0; rx_slot1_valid = 1'b0; rx_slot2_valid = 1'b0;
        g_v1 = tx_slot1_valid; g_w1 = tx_slot1;
        g_v2 = tx_slot2_valid; g_w2 = tx_slot2;
    endtask

    task automatic t_reset_state;
        logic [SW-1:0] v;
        peek(4, v); check("R1 flags after reset", v, 32'h280);
        peek(5, v); check("R1 control after reset", v, 0);
        peek(6, v); check("R1 reset word after reset", v, 0);
        check("R1 codec_rst_n low after reset", codec_rst_n, 0);
        check("R1 no slot sent after reset", tx_slot1_valid, 0);
    endtask

    task automatic t_codec_reset;
        int low;
        bit seen_high;
        wr(6, 1);
        repeat (20) @(negedge clk);
        check("R11 pin held low before hold time", codec_rst_n, 0);
        for (int i = 0; i < 2 * HOLD && !codec_rst_n; i++) @(negedge clk);
        check("R11 pin released after hold", codec_rst_n, 1);
        wr(6, 0);
        low = 0; seen_high = 0;
        for (int i = 0; i < 3 * HOLD && !seen_high; i++) begin
            @(negedge clk);
            if (i == 20) begin bus_wr = 1'b1; bus_addr = 3'd6; bus_wdata = 1; end
            if (i == 21) bus_wr = 1'b0;
            if (i == 30) check("R11 pin low after early re-request", codec_rst_n, 0);
            if (codec_rst_n) seen_high = 1; else low++;
        end
        check("R11 pin eventually released", seen_high, 1);
        check("R11 low time at least hold", (low >= HOLD && low <= HOLD + 3), 1);
    endtask

    task automatic t_write;
        logic [SW-1:0] v;
        wr(5, 20'h79);
        wr(1, 20'hABCD0);
        peek(4, v); check("R4 slot2 busy, slot1 empty", v, 32'h88);
        tick(0, 0, 0, 0);
        check("R3 slot2 alone not sent (s1)", g_v1, 0);
        check("R3 slot2 alone not sent (s2)", g_v2, 0);
        wr(0, 20'h2A000);
        peek(4, v); check("R4 both busy", v, 32'h0A);
        tick(0, 0, 0, 0);
        check("R2 slot1 valid", g_v1, 1);
        check("R2 slot1 index word", g_w1, 32'h2A000);
        check("R2 slot2 valid", g_v2, 1);
        check("R2 slot2 data word", g_w2, 32'hABCD0);
        peek(4, v); check("R4 both empty after send", v, 32'h280);
    endtask

    task automatic t_enables;
        logic [SW-1:0] v;
        wr(5, 20'h69);
        wr(0, 20'h11000);
        tick(0, 0, 0, 0);
        check("R5 slot1 held with tx enable off", g_v1, 0);
        peek(4, v); check("R5 slot1 still busy", v, 32'h202);
        wr(5, 20'h79);
        tick(0, 0, 0, 0);
        check("R5 slot1 sent after enable", g_v1, 1);
        check("R5 slot1 word", g_w1, 32'h11000);
        wr(5, 20'h39);
        wr(1, 20'h55550);
        wr(0, 20'h12000);
        tick(0, 0, 0, 0);
        check("R5 slot1 sent with slot2 tx off", g_v1, 1);
        check("R5 slot2 held with its enable off", g_v2, 0);
        peek(4, v); check("R5 slot2 still busy", v, 32'h88);
        wr(5, 20'h79);
        tick(0, 0, 0, 0);
        check("R3 leftover slot2 not sent alone", g_v2, 0);
        wr(5, 20'h78);
        peek(4, v); check("R9 disable clears busy", v, 32'h280);
        wr(5, 20'h79);
    endtask

    task automatic t_read_echo;
        logic [SW-1:0] v;
        wr(0, 20'hA6000);
        tick(0, 0, 0, 0);
        check("R8 read request word with bit 19", g_w1, 32'hA6000);
        tick(1, 20'h26000, 1, 20'h12340);
        peek(4, v); check("R8 echo match and R6 valid flags", v, 32'h83C0);
        rd(2, v); check("R6 slot1 receive word", v, 32'h26000);
        rd(3, v); check("R6 slot2 receive word", v, 32'h12340);
        peek(4, v); check("R7 reads cleared valid", v, 32'h8280);
        wr(0, 20'hA6000);
        tick(0, 0, 0, 0);
        tick(1, 20'h27000, 0, 0);
        peek(4, v); check("R8 echo mismatch clears flag", v, 32'h2C0);
        rd(2, v);
    endtask

    task automatic t_overwrite;
        logic [SW-1:0] v;
        tick(1, 20'h31000, 0, 0);
        tick(1, 20'h32000, 0, 0);
        rd(2, v); check("R7 newest word overwrites", v, 32'h32000);
        peek(4, v); check("R7 valid cleared by read", v, 32'h280);
        wr(5, 20'h71);
        tick(1, 20'h33000, 0, 0);
        peek(4, v); check("R6 no capture with rx enable off", v, 32'h280);
        peek(2, v); check("R6 stored word untouched", v, 32'h32000);
        wr(5, 20'h79);
    endtask

    task automatic t_disable;
        logic [SW-1:0] v;
        wr(5, 20'h69);
        wr(1, 20'h66660);
        wr(0, 20'h44000);
        tick(1, 20'h45000, 0, 0);
        peek(4, v); check("R9 flags set before disable", v, 32'h4A);
        wr(5, 20'h68);
        peek(4, v); check("R9 disable clears all flags", v, 32'h280);
        tick(1, 20'h46000, 0, 0);
        check("R9 nothing sent while disabled", g_v1, 0);
        peek(4, v); check("R9 nothing captured while disabled", v, 32'h280);
        wr(0, 20'h47000);
        peek(4, v); check("R9 load ignored while disabled", v, 32'h280);
        wr(5, 20'h79);
        tick(0, 0, 0, 0);
        check("R9 discarded load not sent", g_v1, 0);
    endtask

    task automatic t_select;
        logic [SW-1:0] v;
        wr(5, 20'h879);
        peek(5, v);
        check("R10 control readback", v, 32'h879);
        check("R10 codec select 2", codec_sel, 2);
        wr(5, 20'hC79);
        peek(5, v);
        check("R10 codec select 3", codec_sel, 3);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        t_reset_state();
        t_codec_reset();
        t_write();
        t_enables();
        t_read_echo();
        t_overwrite();
        t_disable();
        t_select();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog (all requirements): got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule